// File: doc/BRIEF.md
# Programmable Address Window Decoder

The block maps a 36-bit CPU physical address onto a device target. Software programs up to twenty windows through a simple word-wide register port. Each window has a control word that carries the enable, a 4-bit target code, an 8-bit attribute code and a size. It also has a base word. A leading group of windows adds two remap words, and those words relocate the upper address bits of every access that hits the window.

On each lookup request, every window compares the address with its programmed range in parallel. The lowest-numbered enabled window that matches supplies the target, the attribute and the translated address. These appear on registered outputs one cycle later. When no window matches, the block raises a miss flag.

The register map uses two strides. Remappable windows take 16 bytes each from offset 0x00. A 16-byte hole follows them, and the plain windows then take 8 bytes each. Offsets that belong to no register read as zero, and writes to them have no effect.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, every register reads zero, `rsp_valid_o` is low, and a lookup misses.
- R2: Remappable window w (w < 8) places its words at byte offset 16*w: control at +0x0, base at +0x4, remap low at +0x8 and remap high at +0xC. Each word reads back the value last written to it.
- R3: Plain window w (8 ≤ w < 20) places its words at byte offset 0x90 + 8*(w-8): control at +0x0 and base at +0x4. Each word reads back the value last written to it.
- R4: Offsets 0x80–0x8F and offsets from 0xF0 upward read zero. Writes to them change no register and no lookup result.
- R5: A window hits when all of the following hold:
  - its control bit 0 is set;
  - address bits 35:32 equal base bits 3:0;
  - address bits 31:16 equal base bits 31:16 in every bit position where control bits 31:16 (the size minus one, in 64 KiB units) are zero.
  - The target comes from control bits 7:4 and the attribute from control bits 15:8.
- R6: A window whose control bit 0 is clear never hits, even when its range covers the address. Writing zero to all of a window's words disables it.
- R7: When several windows hit, the lowest-numbered one supplies the outputs.
- R8: On a miss, `miss_o` is 1, `tgt_o` and `attr_o` are 0, and `xlat_addr_o` equals the request address.
- R9: A hit in a remappable window gives the following translated address:
  - bits 35:32 come from remap high bits 3:0;
  - bits 31:16 take remap low bits 31:16 where the size field is zero and keep the address bits where it is one;
  - bits 15:0 pass through unchanged.
- R10: A hit in a plain window passes the address through unchanged.
- R11: Results appear one cycle after `req_valid_i`, with `rsp_valid_o` high for that cycle only. With no request, `rsp_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset; bits 1:0 are ignored |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 36 | Address to decode |
| rsp_valid_o | output | 1 | Lookup result valid |
| miss_o | output | 1 | No enabled window matched |
| tgt_o | output | 4 | Target code of the winning window |
| attr_o | output | 8 | Attribute code of the winning window |
| xlat_addr_o | output | 36 | Translated address |

## Verification
The bench builds the block with its default parameters: twenty windows, eight of them remappable, and a 16-byte hole. These values bring several corners within reach:
- the first and the last remappable window;
- the first plain window, placed directly after the hole;
- the last plain window at offset 0xE8;
- offsets past the end of the map.

Window ranges are chosen so that a remappable window and a plain window overlap, which exercises priority. A window is also disabled at run time, so the lower-priority window underneath it takes over. Other lookups probe the exclusive top of a range, a mismatch in the upper four address bits, and a disabled window whose range covers the address.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned ADDR_W = 36;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TGT_W  = 4;
  localparam int unsigned ATTR_W = 8;
  localparam int unsigned PAGE_W = 16;
  localparam int unsigned HI_W   = ADDR_W - DATA_W;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [PAGE_W-1:0] szm1;
    logic [PAGE_W-1:0] base_lo;
    logic [HI_W-1:0]   base_hi;
    logic              remap_ok;
    logic [PAGE_W-1:0] rmp_lo;
    logic [HI_W-1:0]   rmp_hi;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile #(
  parameter int unsigned NUM_WIN    = 20,
  parameter int unsigned NUM_REMAP  = 8,
  parameter int unsigned HOLE_BYTES = 16,
  parameter int unsigned REG_AW     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [REG_AW-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output awd_pkg::win_cfg_t        cfg_o [NUM_WIN]
);
  localparam int unsigned RMP_END   = NUM_REMAP * 16;
  localparam int unsigned PLN_START = RMP_END + HOLE_BYTES;
  localparam int unsigned PLN_END   = PLN_START + (NUM_WIN - NUM_REMAP) * 8;
  localparam int unsigned WIN_IW    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [31:0]       a_ext;
  logic              sel_vld;
  logic [WIN_IW-1:0] sel_win;
  logic [1:0]        sel_word;  // 0 ctrl, 1 base, 2 remap lo, 3 remap hi

  assign a_ext = 32'(addr_i);

  always_comb begin
    sel_vld  = 1'b0;
    sel_win  = '0;
    sel_word = 2'd0;
    if (a_ext < RMP_END) begin
      sel_vld  = 1'b1;
      sel_win  = WIN_IW'(a_ext >> 4);
      sel_word = a_ext[3:2];
    end else if (a_ext >= PLN_START && a_ext < PLN_END) begin
      sel_vld  = 1'b1;
      sel_win  = WIN_IW'(NUM_REMAP + ((a_ext - PLN_START) >> 3));
      sel_word = {1'b0, a_ext[2]};
    end
  end

  logic [31:0] ctrl_w [NUM_WIN];
  logic [31:0] base_w [NUM_WIN];
  logic [31:0] rlo_w  [NUM_WIN];
  logic [31:0] rhi_w  [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic        wsel;
    logic [31:0] ctrl_q, base_q;

    assign wsel = we_i && sel_vld && (sel_win == WIN_IW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q <= '0;
        base_q <= '0;
      end else begin
        if (wsel && sel_word == 2'd0) ctrl_q <= wdata_i;
        if (wsel && sel_word == 2'd1) base_q <= wdata_i;
      end
    end

    if (w < NUM_REMAP) begin : g_rmp
      logic [31:0] rlo_q, rhi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else begin
          if (wsel && sel_word == 2'd2) rlo_q <= wdata_i;
          if (wsel && sel_word == 2'd3) rhi_q <= wdata_i;
        end
      end
      assign rlo_w[w] = rlo_q;
      assign rhi_w[w] = rhi_q;
    end else begin : g_pln
      assign rlo_w[w] = '0;
      assign rhi_w[w] = '0;
    end

    assign ctrl_w[w] = ctrl_q;
    assign base_w[w] = base_q;

    assign cfg_o[w].en       = ctrl_q[0];
    assign cfg_o[w].tgt      = ctrl_q[7:4];
    assign cfg_o[w].attr     = ctrl_q[15:8];
    assign cfg_o[w].szm1     = ctrl_q[31:16];
    assign cfg_o[w].base_lo  = base_q[31:16];
    assign cfg_o[w].base_hi  = base_q[3:0];
    assign cfg_o[w].remap_ok = (w < NUM_REMAP);
    assign cfg_o[w].rmp_lo   = rlo_w[w][31:16];
    assign cfg_o[w].rmp_hi   = rhi_w[w][3:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_vld) begin
      unique case (sel_word)
        2'd0: rdata_o = ctrl_w[sel_win];
        2'd1: rdata_o = base_w[sel_win];
        2'd2: rdata_o = rlo_w[sel_win];
        2'd3: rdata_o = rhi_w[sel_win];
      endcase
    end
  end
endmodule

// File: rtl/awd_win_cmp.sv
module awd_win_cmp (
  input  awd_pkg::win_cfg_t               cfg_i,
  input  logic [awd_pkg::ADDR_W-1:0]      addr_i,
  output logic                            hit_o,
  output logic [awd_pkg::ADDR_W-1:0]      xlat_o
);
  import awd_pkg::*;

  logic [PAGE_W-1:0] a_pg;
  logic [HI_W-1:0]   a_hi;

  assign a_pg = addr_i[DATA_W-1:PAGE_W];
  assign a_hi = addr_i[ADDR_W-1:DATA_W];

  // size is a power of two, so the size field doubles as the don't-care mask
  assign hit_o = cfg_i.en && (a_hi == cfg_i.base_hi) &&
                 (((a_pg ^ cfg_i.base_lo) & ~cfg_i.szm1) == '0);

  always_comb begin
    if (cfg_i.remap_ok)
      xlat_o = {cfg_i.rmp_hi,
                (cfg_i.rmp_lo & ~cfg_i.szm1) | (a_pg & cfg_i.szm1),
                addr_i[PAGE_W-1:0]};
    else
      xlat_o = addr_i;
  end
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel #(
  parameter int unsigned N  = 20,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder #(
  parameter int unsigned NUM_WIN    = 20,
  parameter int unsigned NUM_REMAP  = 8,
  parameter int unsigned HOLE_BYTES = 16,
  parameter int unsigned REG_AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [35:0]       req_addr_i,
  output logic              rsp_valid_o,
  output logic              miss_o,
  output logic [3:0]        tgt_o,
  output logic [7:0]        attr_o,
  output logic [35:0]       xlat_addr_o
);
  import awd_pkg::*;
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  win_cfg_t            cfg   [NUM_WIN];
  logic [NUM_WIN-1:0]  hit;
  logic [ADDR_W-1:0]   xlat  [NUM_WIN];
  logic                found;
  logic [WIN_IW-1:0]   win_idx;

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP),
    .HOLE_BYTES(HOLE_BYTES), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    awd_win_cmp u_cmp (
      .cfg_i(cfg[w]), .addr_i(req_addr_i),
      .hit_o(hit[w]), .xlat_o(xlat[w])
    );
  end

  awd_prio_sel #(.N(NUM_WIN)) u_sel (
    .hit_i(hit), .found_o(found), .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      miss_o      <= 1'b1;
      tgt_o       <= '0;
      attr_o      <= '0;
      xlat_addr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        miss_o      <= !found;
        tgt_o       <= found ? cfg[win_idx].tgt  : '0;
        attr_o      <= found ? cfg[win_idx].attr : '0;
        xlat_addr_o <= found ? xlat[win_idx] : req_addr_i;
      end
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int unsigned NUM_REMAP  = 8,
  parameter int unsigned HOLE_BYTES = 16,
  parameter int unsigned REG_AW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              req_valid_i,
  input logic [35:0]       req_addr_i,
  input logic              rsp_valid_o,
  input logic              miss_o,
  input logic [3:0]        tgt_o,
  input logic [7:0]        attr_o,
  input logic [35:0]       xlat_addr_o
);
  localparam int unsigned HOLE_LO = NUM_REMAP * 16;
  localparam int unsigned HOLE_HI = HOLE_LO + HOLE_BYTES;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R11
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R11
  AST_MISS_CODES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && miss_o) |-> (tgt_o == '0 && attr_o == '0)); // R8
  AST_MISS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!miss_o || xlat_addr_o == $past(req_addr_i))); // R8
  AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (xlat_addr_o[15:0] == $past(req_addr_i[15:0]))); // R9
  AST_HOLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(reg_addr_i) >= HOLE_LO && 32'(reg_addr_i) < HOLE_HI) |-> reg_rdata_o == '0); // R4
endmodule

bind addr_win_decoder awd_checker #(
  .NUM_REMAP(NUM_REMAP), .HOLE_BYTES(HOLE_BYTES), .REG_AW(REG_AW)
) u_awd_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .req_valid_i(req_valid_i),
  .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o), .miss_o(miss_o),
  .tgt_o(tgt_o), .attr_o(attr_o), .xlat_addr_o(xlat_addr_o)
);

// File: tb/addr_win_decoder_tb_top.sv
module addr_win_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        rsp_valid, miss;
  logic [3:0]  tgt;
  logic [7:0]  attr;
  logic [35:0] xlat;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  addr_win_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .miss_o(miss), .tgt_o(tgt), .attr_o(attr),
    .xlat_addr_o(xlat)
  );

  typedef struct packed {
    logic [35:0] addr;
    logic        miss;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [35:0] xlat;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{36'h0_F10A_BCDE, 1'b0, 4'h3, 8'h1E, 36'h1_200A_BCDE, 4'd7},  // w0 beats w9
    '{36'h0_F100_0000, 1'b0, 4'h3, 8'h1E, 36'h1_2000_0000, 4'd9},
    '{36'h0_F10F_FFFF, 1'b0, 4'h3, 8'h1E, 36'h1_200F_FFFF, 4'd9},
    '{36'h0_F110_0000, 1'b0, 4'h7, 8'h44, 36'h0_F110_0000, 4'd10},
    '{36'h0_F120_0000, 1'b1, 4'h0, 8'h00, 36'h0_F120_0000, 4'd8},
    '{36'h2_8000_1234, 1'b0, 4'hA, 8'hC3, 36'h2_8000_1234, 4'd5},
    '{36'h2_8001_0000, 1'b1, 4'h0, 8'h00, 36'h2_8001_0000, 4'd5},
    '{36'h0_8000_1234, 1'b1, 4'h0, 8'h00, 36'h0_8000_1234, 4'd5},
    '{36'h2_7FFF_FFFF, 1'b1, 4'h0, 8'h00, 36'h2_7FFF_FFFF, 4'd5},
    '{36'h0_4000_0000, 1'b1, 4'h0, 8'h00, 36'h0_4000_0000, 4'd6},
    '{36'h0_3ABC_DEF0, 1'b0, 4'h2, 8'h01, 36'h0_5ABC_DEF0, 4'd9},
    '{36'h0_3FFF_FFFF, 1'b0, 4'h2, 8'h01, 36'h0_5FFF_FFFF, 4'd9}
  };

  function automatic string rtag(input logic [3:0] rq);
    case (rq)
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read 0x%02h: got %08h expected %08h", r, a, reg_rdata, exp);
    end
  endtask

  task automatic look(input vec_t v, input string r);
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || miss !== v.miss || tgt !== v.tgt ||
        attr !== v.attr || xlat !== v.xlat) begin
      n_fail++;
      $display("FAIL %s addr %09h: got v%b m%b t%h a%h x%09h expected v1 m%b t%h a%h x%09h",
               r, v.addr, rsp_valid, miss, tgt, attr, xlat, v.miss, v.tgt, v.attr, v.xlat);
    end
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 rsp_valid held: got %b expected 0", rsp_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 rsp_valid got %b expected 0", rsp_valid);
    end
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h0C, 32'h0, "R1");
    rd_chk(8'hE8, 32'h0, "R1");
    look('{36'h0_0000_0000, 1'b1, 4'h0, 8'h00, 36'h0_0000_0000, 4'd8}, "R1");

    // program windows
    wr(8'h00, 32'h000F_1E31); wr(8'h04, 32'hF100_0000);
    wr(8'h08, 32'h2000_0000); wr(8'h0C, 32'h0000_0001);
    wr(8'h20, 32'h0FFF_0121); wr(8'h24, 32'h3000_0000);
    wr(8'h28, 32'h5000_0000); wr(8'h2C, 32'h0000_0000);
    wr(8'h70, 32'h0000_5560); wr(8'h74, 32'h4000_0000);
    wr(8'h98, 32'h001F_4471); wr(8'h9C, 32'hF100_0000);
    wr(8'hE8, 32'h0000_C3A1); wr(8'hEC, 32'h8000_0002);

    // R2 / R3 readback
    rd_chk(8'h00, 32'h000F_1E31, "R2");
    rd_chk(8'h0C, 32'h0000_0001, "R2");
    rd_chk(8'h28, 32'h5000_0000, "R2");
    rd_chk(8'h74, 32'h4000_0000, "R2");
    rd_chk(8'h98, 32'h001F_4471, "R3");
    rd_chk(8'hE8, 32'h0000_C3A1, "R3");
    rd_chk(8'hEC, 32'h8000_0002, "R3");

    // vector table: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) look(VECS[i], rtag(VECS[i].rq));

    // R4 hole and out-of-map writes ignored
    wr(8'h84, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk(8'h84, 32'h0, "R4");
    rd_chk(8'hF0, 32'h0, "R4");
    rd_chk(8'h7C, 32'h0, "R4");
    rd_chk(8'h80, 32'h0, "R4");
    rd_chk(8'h90, 32'h0, "R4");
    look('{36'h0_0000_0000, 1'b1, 4'h0, 8'h00, 36'h0_0000_0000, 4'd8}, "R4");

    // R6 disable w0 by zeroing; w9 takes over (R7)
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    rd_chk(8'h08, 32'h0, "R6");
    look('{36'h0_F10A_BCDE, 1'b0, 4'h7, 8'h44, 36'h0_F10A_BCDE, 4'd6}, "R6");

    // R6 enable w7: now hits and remaps with zero remap words (R9)
    wr(8'h70, 32'h0000_5561);
    look('{36'h0_4000_ABCD, 1'b0, 4'h6, 8'h55, 36'h0_0000_ABCD, 4'd9}, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule